// File: doc/BRIEF.md
# Prescaled 8-bit PWM controller

A single-channel pulse-width modulator with a small synchronous register interface. Software picks the tick source: every system clock, or the rising edges of a slow asynchronous clock brought across by a synchroniser. It also sets a power-of-two prescaler, an 8-bit compare value and the output polarity. One output period is always 256 prescaled ticks. The output is active while the period counter is below the compare value, so the duty cycle ranges from 0/256 to 255/256 and never reaches a fully active period.

The channel is started and stopped through two separate write-one registers. A status bit follows the run request after it has crossed a synchroniser, and software polls that bit. Compare, polarity, prescaler and source changes made while the channel runs are held back until the next period begins. While stopped, the counter sits at zero and the output rests at its inactive level.

Top module: `pwm8_ctrl`

## Requirements
- R1: After reset, registers GEN (word address 0), CFG (address 1) and STATUS (address 4) read 0, and pwm_out is 1 (the inactive level for polarity bit 0).
- R2: CFG holds the compare value in bits 15:8, the polarity bit in bit 4 and the prescaler select in bits 2:0; GEN holds the source select in bit 0. All other bits read 0, and addresses 2 and 3 read 0.
- R3: With GEN bit 0 set, one prescaled tick occurs every 2^N system clocks (N = prescaler select), a period lasts 256 prescaled ticks, and pwm_out is active for compare x 2^N clocks per period.
- R4: Compare 0 gives no active clock in a period; compare 255 gives 255 of 256 ticks active and always at least one inactive tick.
- R5: With CFG bit 4 set the active level is 1; with it clear the output is inverted, so it reads 1 for (256 - compare) x 2^N clocks per period.
- R6: With GEN bit 0 clear, ticks are the rising edges of slow_clk after synchronisation, so each counter step lasts 2^N slow_clk periods.
- R7: A prescaler select of 7 behaves as 6, and the field still reads back as written.
- R8: Writing 1 to bit 0 at address 2 requests run; writing 1 to bit 0 at address 3 requests stop; writes with bit 0 clear to either address change nothing.
- R9: STATUS bit 0 follows the run request exactly two system clocks after the write edge (SYNC_STAGES = 2).
- R10: Changes to CFG made while running take effect at the next period boundary, never inside the current period.
- R11: While stopped, pwm_out holds the inactive level of the current polarity bit, and a restart begins a fresh period at counter 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the bus and the PWM engine |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow asynchronous clock, used as the tick source when selected |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clk edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The duty function is driven with compare values 0, 1, 64, 200 and 255 across several prescaler settings and both polarities. Counting active clocks over one whole period separates a wrong divider, a wrong compare test and a swapped polarity. The slow source separates edge-driven ticks from ticks on every clock, and prescaler 7 separates clamping from an 8th divider step. A write made in the middle of a period, followed by an exact restart sequence, shows whether the configuration is held back to the period boundary and whether the counter is reset while stopped.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
   // compare field width fixes the period at 256 ticks
   localparam int CMP_W   = 8;
   localparam int PS_W    = 3;
   // field positions decoded by software
   localparam int CMP_LSB = 8;
   localparam int POL_BIT = 4;
   localparam int PS_LSB  = 0;
   localparam int SEL_BIT = 0;
   localparam int RUN_BIT = 0;
   // word addresses
   localparam int REG_GEN  = 0;
   localparam int REG_CFG  = 1;
   localparam int REG_SET  = 2;
   localparam int REG_CLR  = 3;
   localparam int REG_STAT = 4;

   typedef struct packed {
      logic             fast_sel;
      logic [CMP_W-1:0] cmp;
      logic             act_high;
      logic [PS_W-1:0]  ps;
   } pwm_cfg_t;
endpackage

// File: rtl/pwm8_sync.sv
module pwm8_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwm8_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm8_regs.sv
module pwm8_regs
   import pwm8_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              status_in,
   output pwm_cfg_t          cfg_o,
   output logic              run_req_o
);
   if (DATA_W < CMP_LSB + CMP_W) begin : g_bad_data
      $error("pwm8_regs: DATA_W too narrow for the compare field");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pwm8_regs: ADDR_W must reach address 4");
   end

   localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(REG_GEN);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(REG_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(REG_CLR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

   pwm_cfg_t cfg_q;
   logic     run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= 1'b0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_GEN: cfg_q.fast_sel <= bus_wdata[SEL_BIT];
            A_CFG: begin
               cfg_q.cmp      <= bus_wdata[CMP_LSB +: CMP_W];
               cfg_q.act_high <= bus_wdata[POL_BIT];
               cfg_q.ps       <= bus_wdata[PS_LSB +: PS_W];
            end
            A_SET: if (bus_wdata[RUN_BIT]) run_q <= 1'b1;
            A_CLR: if (bus_wdata[RUN_BIT]) run_q <= 1'b0;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_GEN: bus_rdata[SEL_BIT] = cfg_q.fast_sel;
         A_CFG: begin
            bus_rdata[CMP_LSB +: CMP_W] = cfg_q.cmp;
            bus_rdata[POL_BIT]          = cfg_q.act_high;
            bus_rdata[PS_LSB +: PS_W]   = cfg_q.ps;
         end
         A_STAT: bus_rdata[RUN_BIT] = status_in;
         default: ;
      endcase
   end

   assign cfg_o     = cfg_q;
   assign run_req_o = run_q;

   // R8: a stop request always clears the run request
   assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CLR && bus_wdata[RUN_BIT]) |=> !run_q);
   // R8: writes with the control bit clear leave the request alone
   assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_SET || bus_addr == A_CLR) && !bus_wdata[RUN_BIT])
      |=> (run_q == $past(run_q)));
endmodule

// File: rtl/pwm8_tickgen.sv
module pwm8_tickgen
   import pwm8_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PS_MAX      = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_clk,
   input  logic            run,
   input  logic            fast_sel,
   input  logic [PS_W-1:0] ps_sel,
   output logic            ptick
);
   if (PS_MAX < 1 || PS_MAX >= (1 << PS_W)) begin : g_bad_ps
      $error("pwm8_tickgen: PS_MAX out of range for the select field");
   end

   localparam int PRE_W = PS_MAX;

   logic             slow_s, slow_prev, src_tick;
   logic [PS_W-1:0]  ps_eff;
   logic [PRE_W-1:0] pre_cnt, pre_lim;

   pwm8_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (slow_clk),
      .q     (slow_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slow_prev <= 1'b0;
      else        slow_prev <= slow_s;
   end

   always_comb begin
      ps_eff   = (ps_sel > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : ps_sel;
      pre_lim  = PRE_W'((1 << ps_eff) - 1);
      src_tick = fast_sel | (slow_s & ~slow_prev);
      ptick    = run & src_tick & (pre_cnt == pre_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_cnt <= '0;
      else if (!run)     pre_cnt <= '0;
      else if (src_tick) pre_cnt <= (pre_cnt == pre_lim) ? '0 : pre_cnt + 1'b1;
   end

   // R7: the divider count never passes the clamped limit
   assert_presc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pre_cnt <= pre_lim));
   // R11: the divider is held at zero while stopped
   assert_presc_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_cnt == '0));
endmodule

// File: rtl/pwm8_engine.sv
module pwm8_engine
   import pwm8_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PS_MAX      = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     slow_clk,
   input  logic     run,
   input  pwm_cfg_t cfg,
   output logic     pwm_out
);
   pwm_cfg_t         sh;
   logic [CMP_W-1:0] cnt;
   logic             ptick, out_q;

   pwm8_tickgen #(.SYNC_STAGES(SYNC_STAGES), .PS_MAX(PS_MAX)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow_clk (slow_clk),
      .run      (run),
      .fast_sel (sh.fast_sel),
      .ps_sel   (sh.ps),
      .ptick    (ptick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         out_q <= 1'b1;
      end else begin
         if (!run) begin
            sh  <= cfg;
            cnt <= '0;
         end else if (ptick) begin
            cnt <= cnt + 1'b1;
            if (cnt == '1) sh <= cfg;
         end
         if (!run) out_q <= ~cfg.act_high;
         else      out_q <= (cnt < sh.cmp) ? sh.act_high : ~sh.act_high;
      end
   end

   assign pwm_out = out_q;

   // R4: the last tick of every period is inactive
   assert_never_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == '1) |=> (pwm_out != $past(sh.act_high)));
   // R10: settings in use only move at a period boundary
   assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(ptick && cnt == '1)) |=> $stable(sh));
   // R11: the period counter is held at zero while stopped
   assert_cnt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/pwm8_ctrl.sv
module pwm8_ctrl
   import pwm8_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int PS_MAX      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);
   pwm_cfg_t cfg;
   logic     run_req, run_s;

   pwm8_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .status_in (run_s),
      .cfg_o     (cfg),
      .run_req_o (run_req)
   );

   pwm8_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (run_req),
      .q     (run_s)
   );

   pwm8_engine #(.SYNC_STAGES(SYNC_STAGES), .PS_MAX(PS_MAX)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow_clk (slow_clk),
      .run      (run_s),
      .cfg      (cfg),
      .pwm_out  (pwm_out)
   );

   // R9: status rises only for a request made SYNC_STAGES clocks earlier
   assert_status_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_s) |-> $past(run_req, SYNC_STAGES));
   // R9: status falls only for a stop made SYNC_STAGES clocks earlier
   assert_status_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_s) |-> !$past(run_req, SYNC_STAGES));
endmodule

// File: tb/pwm8_ctrl_test.sv
module pwm8_ctrl_test;
   logic        clk, rst_n, slow_clk, wr, pwm_out;
   logic [2:0]  addr;
   logic [31:0] wdata, rdata;
   int n_chk = 0;
   int n_bad = 0;

   pwm8_ctrl uut (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_addr(addr),
      .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out)
   );

   initial begin clk = 0; forever #10 clk = ~clk; end
   initial begin slow_clk = 0; #5; forever #80 slow_clk = ~slow_clk; end

   task automatic chk(input string rq, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   function automatic logic [31:0] cfg_word(input int cmp, input int pol, input int ps);
      return (32'(cmp) << 8) | (32'(pol) << 4) | 32'(ps);
   endfunction

   task automatic wait_status(input string rq, input logic want);
      logic [31:0] v;
      int k = 0;
      bus_read(3'd4, v);
      while (v[0] !== want && k < 20) begin
         @(negedge clk); bus_read(3'd4, v); k++;
      end
      chk(rq, v[0], want);
   endtask

   task automatic measure(input int len, output int hi);
      hi = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk); if (pwm_out) hi++;
      end
   endtask

   task automatic run_pattern(input string rq, input int fast, input int cmp, input int pol,
                              input int ps, input int settle, input int len, input int exp_hi);
      int hi;
      bus_write(3'd0, 32'(fast));
      bus_write(3'd1, cfg_word(cmp, pol, ps));
      bus_write(3'd2, 32'h1);
      wait_status(rq, 1'b1);
      repeat (settle) @(negedge clk);
      measure(len, hi);
      chk(rq, hi, exp_hi);
      bus_write(3'd3, 32'h1);
      wait_status(rq, 1'b0);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      bus_read(3'd0, v); chk("R1 gen", v, 0);
      bus_read(3'd1, v); chk("R1 cfg", v, 0);
      bus_read(3'd4, v); chk("R1 status", v, 0);
      chk("R1 out", pwm_out, 1);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      bus_write(3'd1, 32'hFFFF_FFFF); bus_read(3'd1, v); chk("R2 cfg fields", v, 32'h0000_FF17);
      bus_write(3'd0, 32'hFFFF_FFFF); bus_read(3'd0, v); chk("R2 gen field", v, 1);
      bus_read(3'd2, v); chk("R2 set reads 0", v, 0);
      bus_read(3'd3, v); chk("R2 clr reads 0", v, 0);
      bus_write(3'd0, 32'h0); bus_write(3'd1, 32'h0);
   endtask

   task automatic t_duty;
      run_pattern("R3 cmp64 ps0", 1, 64, 1, 0, 4, 256, 64);
      run_pattern("R3 R5 cmp200 inverted ps2", 1, 200, 0, 2, 4, 1024, 224);
      run_pattern("R3 cmp1 ps1", 1, 1, 1, 1, 4, 512, 2);
      run_pattern("R5 cmp64 inverted ps0", 1, 64, 0, 0, 4, 256, 192);
   endtask

   task automatic t_edges;
      run_pattern("R4 cmp0", 1, 0, 1, 0, 4, 256, 0);
      run_pattern("R4 cmp255", 1, 255, 1, 0, 4, 512, 510);
   endtask

   task automatic t_slow;
      run_pattern("R6 slow ps0", 0, 32, 1, 0, 2100, 2048, 256);
      run_pattern("R6 slow ps1", 0, 32, 1, 1, 4200, 4096, 512);
   endtask

   task automatic t_presc7;
      logic [31:0] v;
      bus_write(3'd1, cfg_word(64, 1, 7));
      bus_read(3'd1, v); chk("R7 readback", v, 32'h0000_4017);
      run_pattern("R7 ps7 as ps6", 1, 64, 1, 7, 4, 16384, 4096);
   endtask

   task automatic t_ctrl;
      logic [31:0] v;
      bus_write(3'd2, 32'hFFFF_FFFE);
      repeat (4) @(negedge clk);
      bus_read(3'd4, v); chk("R8 set with bit0 clear", v[0], 0);
      bus_write(3'd2, 32'h1);
      bus_read(3'd4, v); chk("R9 lag +0", v[0], 0);
      @(negedge clk); bus_read(3'd4, v); chk("R9 lag +1", v[0], 0);
      @(negedge clk); bus_read(3'd4, v); chk("R9 lag +2", v[0], 1);
      bus_write(3'd3, 32'hFFFF_FFFE);
      repeat (4) @(negedge clk);
      bus_read(3'd4, v); chk("R8 clr with bit0 clear", v[0], 1);
      bus_write(3'd3, 32'h1);
      bus_read(3'd4, v); chk("R9 stop lag +0", v[0], 1);
      @(negedge clk); bus_read(3'd4, v); chk("R9 stop lag +1", v[0], 1);
      @(negedge clk); bus_read(3'd4, v); chk("R8 R9 stop lag +2", v[0], 0);
   endtask

   task automatic t_update;
      int hi, k;
      bus_write(3'd0, 32'h1);
      bus_write(3'd1, cfg_word(64, 1, 0));
      bus_write(3'd2, 32'h1);
      wait_status("R10 start", 1'b1);
      k = 0;
      while (pwm_out !== 1'b0 && k < 600) begin @(negedge clk); k++; end
      while (pwm_out !== 1'b1 && k < 600) begin @(negedge clk); k++; end
      repeat (96) @(negedge clk);
      bus_write(3'd1, cfg_word(192, 1, 0));
      measure(140, hi);
      chk("R10 no change mid period", hi, 0);
      k = 0;
      while (pwm_out !== 1'b1 && k < 600) begin @(negedge clk); k++; end
      measure(255, hi);
      chk("R10 next period uses new compare", hi + 1, 192);
      bus_write(3'd3, 32'h1);
      wait_status("R10 stop", 1'b0);
   endtask

   task automatic t_stop;
      int hi;
      bus_write(3'd0, 32'h1);
      bus_write(3'd1, cfg_word(128, 1, 0));
      bus_write(3'd2, 32'h1);
      wait_status("R11 start", 1'b1);
      repeat (50) @(negedge clk);
      bus_write(3'd3, 32'h1);
      wait_status("R11 stop", 1'b0);
      repeat (2) @(negedge clk);
      chk("R11 idle level polarity 1", pwm_out, 0);
      bus_write(3'd1, cfg_word(16, 0, 0));
      repeat (2) @(negedge clk);
      chk("R11 idle level polarity 0", pwm_out, 1);
      bus_write(3'd1, cfg_word(16, 1, 0));
      bus_write(3'd2, 32'h1);
      @(negedge clk); @(negedge clk);
      measure(16, hi);
      chk("R11 restart from counter 0", hi, 16);
      @(negedge clk);
      chk("R11 restart first inactive tick", pwm_out, 0);
      bus_write(3'd3, 32'h1);
      wait_status("R11 final stop", 1'b0);
   endtask

   initial begin
      rst_n = 0; wr = 0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_ctrl;
      t_duty;
      t_edges;
      t_slow;
      t_presc7;
      t_update;
      t_stop;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule